// File: doc/BRIEF.md
# Averaging Block-Length Matching Downsampler

This block sits in front of a power-of-two transform in a code-acquisition datapath. One spreading-code period carries `N_IN` complex samples, and `N_IN` is generally not a power of two. The block turns one period into exactly `2**LOG2_OUT` complex outputs. It splits the period into consecutive groups and averages each group. The I and Q lanes move together, and each output is one complex value with I as the real part and Q as the imaginary part. No input sample is dropped inside a framed period.

Group boundaries come from a fractional phase that advances by `N_IN / 2**LOG2_OUT` per output. Each group therefore holds either the floor or the ceiling of that ratio, and each group sum is divided by its own size. The same instance type serves both the received baseband stream and the local code replica, so both transform inputs have the same length.

A period begins on an accepted sample that carries the start marker. The outputs of a period are framed by a flag on the final one. Results are rounded to nearest and clamped to a narrower output width.

Top module: `blkavg_ds`

## Requirements
- R1: While `rst` is high, `out_valid` and `in_ready` are 0 on the next clock. From the second clock after reset is released, `in_ready` is 1.
- R2: An accepted sample with `in_start`=1, followed by `N_IN`-1 more accepted samples, yields exactly `2**LOG2_OUT` outputs. `out_last` is 1 on the final output only.
- R3: With M = `2**LOG2_OUT`, output j of a period averages the input positions floor(j*N_IN/M) through floor((j+1)*N_IN/M)-1, counted from 0 at the start-marked sample. Group sizes are therefore floor or ceiling of N_IN/M.
- R4: Each output lane equals its group's signed sum divided by the group size, rounded to nearest with exact halves going away from zero. I and Q are averaged independently (`out_i` from `in_i`, `out_q` from `in_q`).
- R5: A rounded average outside the signed `OUT_W`-bit range is clamped to -2**(`OUT_W`-1) or 2**(`OUT_W`-1)-1.
- R6: `out_valid` pulses for one cycle, two rising edges after the edge that accepts the group's final sample.
- R7: A cycle with `in_valid`=0 has no effect on grouping or sums.
- R8: Accepted samples before any start marker, or after a period has completed and before the next start marker, produce no output.
- R9: A start marker in the middle of a period discards the unfinished group. The remaining outputs of that period are not produced, and a new period begins at the marked sample.
- R10: A new period may begin on the cycle right after the previous period's last sample, with no lost or extra outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block accepts samples (high outside reset) |
| in_start | input | 1 | Marks the first sample of a code period |
| in_i | input | IN_W | In-phase sample, two's complement |
| in_q | input | IN_W | Quadrature sample, two's complement |
| out_valid | output | 1 | Averaged output present |
| out_last | output | 1 | Final output of the period |
| out_i | output | OUT_W | Real part of the average |
| out_q | output | OUT_W | Imaginary part of the average |

## Verification
The assertions assume that `in_valid` is raised only once `in_ready` has come up after reset. They also assume the downstream consumer never stalls, because the output has no backpressure. The latency property ties every output pulse to an accepted sample two edges earlier, which holds only while inputs arrive through the handshake. The bench therefore waits several cycles after reset before driving. It raises `in_start` only together with `in_valid`, and it changes data only on falling edges. Gaps, stray samples, restarts and back-to-back periods are all produced within those limits.

// File: rtl/blkavg_pkg.sv
package blkavg_pkg;
  typedef struct packed {
    logic first;    // sample opens a group
    logic grp_end;  // sample closes a group
    logic blk_end;  // sample closes the period
    logic big;      // current group has the ceiling size
  } grp_ctl_t;
endpackage

// File: rtl/blkavg_phase.sv
module blkavg_phase #(
  parameter int N_IN     = 21,
  parameter int LOG2_OUT = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fire,
  input  logic                  start,
  output logic                  take,
  output blkavg_pkg::grp_ctl_t  ctl
);
  localparam int M  = 1 << LOG2_OUT;
  localparam int Q  = N_IN / M;
  localparam int R  = N_IN % M;
  localparam int CW = $clog2(Q + 2);
  localparam int FW = $clog2(2 * M) + 1;
  localparam int IW = LOG2_OUT;
  localparam logic [FW-1:0] R_F = FW'(R);
  localparam logic [FW-1:0] M_F = FW'(M);
  localparam logic [CW-1:0] Q_C = CW'(Q);

  logic          active;
  logic [CW-1:0] cnt, c_cnt, size;
  logic [FW-1:0] frac, c_frac, sum_f, nfrac;
  logic [IW-1:0] idx, c_idx;

  always_comb begin
    c_cnt  = start ? '0 : cnt;
    c_frac = start ? '0 : frac;
    c_idx  = start ? '0 : idx;
    sum_f  = c_frac + R_F;
    ctl.big = (sum_f >= M_F);
    nfrac  = ctl.big ? (sum_f - M_F) : sum_f;
    size   = Q_C + CW'(ctl.big);
    ctl.first   = (c_cnt == '0);
    ctl.grp_end = (CW'(c_cnt + 1'b1) == size);
    ctl.blk_end = ctl.grp_end && (&c_idx);
    take = fire && (start || active);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      frac   <= '0;
      idx    <= '0;
    end else if (take) begin
      if (ctl.grp_end) begin
        cnt    <= '0;
        frac   <= nfrac;
        idx    <= c_idx + 1'b1;
        active <= !ctl.blk_end;
      end else begin
        cnt    <= c_cnt + 1'b1;
        frac   <= c_frac;
        idx    <= c_idx;
        active <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/blkavg_acc.sv
module blkavg_acc #(
  parameter int IN_W = 8,
  parameter int AW   = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     take,
  input  blkavg_pkg::grp_ctl_t     ctl,
  input  logic [1:0][IN_W-1:0]     smp,
  output logic                     s_valid,
  output logic                     s_big,
  output logic                     s_last,
  output logic [1:0][AW-1:0]       s_sum
);
  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic signed [AW-1:0] acc_q, sum_q, nxt;
    always_comb nxt = (ctl.first ? AW'(0) : acc_q) + AW'($signed(smp[g]));
    always_ff @(posedge clk) begin
      if (rst) begin
        acc_q <= '0;
        sum_q <= '0;
      end else if (take) begin
        acc_q <= ctl.grp_end ? AW'(0) : nxt;
        if (ctl.grp_end) sum_q <= nxt;
      end
    end
    assign s_sum[g] = sum_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_valid <= 1'b0;
      s_big   <= 1'b0;
      s_last  <= 1'b0;
    end else begin
      s_valid <= take && ctl.grp_end;
      if (take && ctl.grp_end) begin
        s_big  <= ctl.big;
        s_last <= ctl.blk_end;
      end
    end
  end
endmodule

// File: rtl/blkavg_div.sv
module blkavg_div #(
  parameter int AW    = 10,
  parameter int OUT_W = 6,
  parameter int Q     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             big,
  input  logic [AW-1:0]    sum,
  output logic [OUT_W-1:0] q_out
);
  localparam int SW = AW + 3;
  localparam logic [SW-1:0] D0 = SW'(Q);
  localparam logic [SW-1:0] D1 = SW'(Q + 1);
  localparam logic [SW-1:0] H0 = SW'(Q / 2);
  localparam logic [SW-1:0] H1 = SW'((Q + 1) / 2);
  localparam logic signed [SW-1:0] MAXV = SW'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [SW-1:0] MINV = -MAXV - SW'(1);

  logic                 neg;
  logic signed [SW-1:0] sx, res, clamped;
  logic [SW-1:0]        mag, quo;

  always_comb begin
    neg = sum[AW-1];
    sx  = SW'($signed(sum));
    mag = neg ? SW'(-sx) : SW'(sx);
    quo = big ? (mag + H1) / D1 : (mag + H0) / D0;
    res = neg ? -$signed(quo) : $signed(quo);
    if (res > MAXV)      clamped = MAXV;
    else if (res < MINV) clamped = MINV;
    else                 clamped = res;
  end

  always_ff @(posedge clk) begin
    if (rst)     q_out <= '0;
    else if (en) q_out <= OUT_W'(clamped);
  end
endmodule

// File: rtl/blkavg_ds.sv
module blkavg_ds #(
  parameter int IN_W     = 8,
  parameter int OUT_W    = 6,
  parameter int N_IN     = 21,
  parameter int LOG2_OUT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_start,
  input  logic [IN_W-1:0]  in_i,
  input  logic [IN_W-1:0]  in_q,
  output logic             out_valid,
  output logic             out_last,
  output logic [OUT_W-1:0] out_i,
  output logic [OUT_W-1:0] out_q
);
  localparam int M  = 1 << LOG2_OUT;
  localparam int Q  = N_IN / M;
  localparam int AW = IN_W + $clog2(Q + 2);

  blkavg_pkg::grp_ctl_t ctl;
  logic                 take, s_valid, s_big, s_last;
  logic [1:0][AW-1:0]   s_sum;
  logic [1:0][OUT_W-1:0] avg;

  always_ff @(posedge clk) begin
    if (rst) in_ready <= 1'b0;
    else     in_ready <= 1'b1;
  end

  blkavg_phase #(.N_IN(N_IN), .LOG2_OUT(LOG2_OUT)) u_phase (
    .clk(clk), .rst(rst), .fire(in_valid && in_ready),
    .start(in_start), .take(take), .ctl(ctl)
  );

  blkavg_acc #(.IN_W(IN_W), .AW(AW)) u_acc (
    .clk(clk), .rst(rst), .take(take), .ctl(ctl),
    .smp({in_q, in_i}), .s_valid(s_valid), .s_big(s_big),
    .s_last(s_last), .s_sum(s_sum)
  );

  for (genvar g = 0; g < 2; g++) begin : g_div
    blkavg_div #(.AW(AW), .OUT_W(OUT_W), .Q(Q)) u_div (
      .clk(clk), .rst(rst), .en(s_valid), .big(s_big),
      .sum(s_sum[g]), .q_out(avg[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= s_valid;
      out_last  <= s_valid && s_last;
    end
  end

  assign out_i = avg[0];
  assign out_q = avg[1];
endmodule

// File: rtl/blkavg_chk.sv
module blkavg_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_last
);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && !in_ready));

  assert_ready_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> in_ready);

  assert_last_valid_R2: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && in_ready, 2));
endmodule

bind blkavg_ds blkavg_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_last(out_last)
);

// File: tb/blkavg_ds_tb.sv
`timescale 1ns/1ps
module blkavg_ds_tb;
  localparam int IN_W = 8, OUT_W = 6, N = 21, M = 8;
  localparam int OMAX = (1 << (OUT_W - 1)) - 1;
  localparam int OMIN = -(1 << (OUT_W - 1));

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_start = 0;
  logic signed [IN_W-1:0] in_i = 0, in_q = 0;
  logic in_ready, out_valid, out_last;
  logic signed [OUT_W-1:0] out_i, out_q;

  always #2.5 clk = ~clk;

  blkavg_ds u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_start(in_start), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_last(out_last), .out_i(out_i), .out_q(out_q)
  );

  typedef struct { int i; int q; bit last; int due; } exp_t;
  exp_t eq[$];
  int checks = 0, errors = 0, cyc = 0, n_out = 0;
  int last_i = 0, last_q = 0;
  bit done = 0;
  string tag = "R1";

  bit m_active = 0;
  int m_pos, m_j, m_si, m_sq, m_cnt;

  function automatic int avg(int s, int d);
    int a, r;
    a = (s < 0) ? -s : s;
    r = (a + d / 2) / d;
    r = (s < 0) ? -r : r;
    if (r > OMAX) r = OMAX;
    if (r < OMIN) r = OMIN;
    return r;
  endfunction

  // behavioural reference: floor-based group ends per accepted sample
  always @(posedge clk) begin
    if (rst) begin
      m_active = 0;
      eq.delete();
    end else if (in_valid) begin
      if (in_start) begin
        m_active = 1; m_pos = 0; m_j = 0; m_si = 0; m_sq = 0; m_cnt = 0;
      end
      if (m_active) begin
        m_si += int'(in_i); m_sq += int'(in_q); m_cnt++; m_pos++;
        if (m_pos == ((m_j + 1) * N) / M) begin
          exp_t e;
          e.i = avg(m_si, m_cnt); e.q = avg(m_sq, m_cnt);
          e.last = (m_j == M - 1); e.due = cyc + 2;
          eq.push_back(e);
          m_si = 0; m_sq = 0; m_cnt = 0; m_j++;
          if (m_j == M) m_active = 0;
        end
      end
    end
    cyc = cyc + 1;
  end

  // per-cycle comparison (R2 R3 R4 R5 R6)
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin n_out++; last_i = int'(out_i); last_q = int'(out_q); end
      if (eq.size() > 0 && eq[0].due == cyc) begin
        checks++;
        if (!out_valid || int'(out_i) != eq[0].i || int'(out_q) != eq[0].q
            || out_last != eq[0].last) begin
          errors++;
          $display("FAIL %s R4/R6 out v=%0d i=%0d q=%0d last=%0d expected v=1 i=%0d q=%0d last=%0d",
                   tag, out_valid, out_i, out_q, out_last, eq[0].i, eq[0].q, eq[0].last);
        end
        void'(eq.pop_front());
      end else if (out_valid) begin
        checks++; errors++;
        $display("FAIL %s R8 spurious output i=%0d q=%0d expected none", tag, out_i, out_q);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic send(input bit st, input int vi, input int vq);
    @(negedge clk);
    in_valid = 1; in_start = st; in_i = IN_W'(vi); in_q = IN_W'(vq);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 0; in_start = 0;
      in_i = IN_W'($urandom); in_q = IN_W'($urandom);
    end
  endtask

  // mode 0 small random, 1 full random, 2 extremes, 3 rounding pattern
  task automatic block(input int mode, input int len, input bit gaps);
    for (int p = 0; p < len; p++) begin
      int vi, vq;
      case (mode)
        0: begin vi = $urandom_range(40) - 20; vq = $urandom_range(40) - 20; end
        1: begin vi = $urandom_range(255) - 128; vq = $urandom_range(255) - 128; end
        2: begin vi = 127; vq = -128; end
        default: begin vi = (p % 2) ? 2 : 1; vq = (p % 2) ? -2 : -1; end
      endcase
      if (gaps && ($urandom_range(2) == 0)) idle(1 + $urandom_range(2));
      send(p == 0, vi, vq);
    end
    idle(1);
  endtask

  task automatic expect_count(input int base, input int n, input string req);
    idle(6);
    check(n_out - base == n, req, n_out - base, n);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R1 out_valid in reset", out_valid, 0);
    check(in_ready == 0, "R1 in_ready in reset", in_ready, 0);
    rst = 0;
    idle(3);
    check(in_ready == 1, "R1 in_ready after reset", in_ready, 1);

    tag = "R8"; base = n_out;
    for (int k = 0; k < 5; k++) send(0, 50, -50);
    expect_count(base, 0, "R8 before start");

    tag = "R3"; base = n_out;
    block(0, N, 0);
    expect_count(base, M, "R2 R3 outputs per period");

    tag = "R7"; base = n_out;
    block(0, N, 1);
    expect_count(base, M, "R7 period with gaps");

    tag = "R8"; base = n_out;
    for (int k = 0; k < 6; k++) send(0, 10, 10);
    expect_count(base, 0, "R8 after period end");

    tag = "R5"; base = n_out;
    block(2, N, 0);
    expect_count(base, M, "R5 clamp period");
    check(last_i == OMAX, "R5 positive clamp", last_i, OMAX);
    check(last_q == OMIN, "R5 negative clamp", last_q, OMIN);

    tag = "R4"; base = n_out;
    block(3, N, 0);
    expect_count(base, M, "R4 rounding period");

    tag = "R4"; base = n_out;
    block(1, N, 1);
    expect_count(base, M, "R4 full range period");

    tag = "R9"; base = n_out;
    for (int p = 0; p < 9; p++) send(p == 0, p, -p);
    block(0, N, 0);
    expect_count(base, 3 + M, "R9 restart mid period");

    tag = "R10"; base = n_out;
    for (int b = 0; b < 2; b++)
      for (int p = 0; p < N; p++)
        send(p == 0, $urandom_range(60) - 30, $urandom_range(60) - 30);
    expect_count(base, 2 * M, "R10 back to back periods");

    check(eq.size() == 0, "R2 pending outputs", eq.size(), 0);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule